// File: doc/BRIEF.md
# GPIO Port with Interrupt Routing

A register-mapped general purpose I/O block with sixteen lines. Software reaches it over a plain register bus that carries a byte address, a write strobe, write data and combinational read data. Each line presents an output value and an output-enable to a tri-state pad cell. The direction register sets the enable, and the output register sets the value driven. Every pad input passes through a two-flop synchronizer. The synchronized value can be read and also feeds the interrupt logic.

Each line can raise an interrupt. A mask bit gates it. An edge-select bit picks level or edge sensing, and a polarity bit picks high/low or rising/falling. A per-line map field steers the line's event onto one bit of a 32-bit interrupt vector, starting at bit 16. Several lines may share one bit. The block also has a pulse-toggle feature: with its enable set, a strobe on a line's internal pulse input inverts that line's output register bit.

Top module: `gpio_irq_port`

## Requirements
- R1: The data word (byte offset 0x00) returns the pad inputs in bits 15:0 after two clock edges of synchronization, so a pad change made between edges is not visible after one edge and is visible after two. Writes to offset 0x00 have no effect.
- R2: The direction register (offset 0x08, bit i for line i) drives `pad_oe` directly. A 1 enables the line's driver.
- R3: The output register (offset 0x04, bit i for line i) drives `pad_out` directly.
- R4: A line whose mask bit (offset 0x0C) is 0 never sets any `irq_out` bit.
- R5: With its edge-select bit (offset 0x14) at 0, a line is level sensitive. Polarity (offset 0x10) 1 means active high and 0 means active low. The mapped `irq_out` bit is held for as long as the synchronized level matches, and it is registered one edge after the value appears in the data word.
- R6: With its edge-select bit at 1, polarity 1 reacts to rising edges and polarity 0 to falling edges of the synchronized input. Each edge produces a one-clock pulse on the mapped bit, registered one edge after the new value appears in the data word.
- R7: Map word k (offset 0x20+4k) holds the fields for lines 4k..4k+3. Line 4k+j uses bits 8j+4..8j of that word. A field value m drives `irq_out[16+m]`. Lines with the same m are ORed. Values 16..31 drive nothing, and `irq_out[15:0]` stays 0.
- R8: The pulse-enable register (offset 0x18) decides whether a strobe on `pulse_in[i]` inverts output bit i at the next edge. With the enable at 0 the strobe has no effect. A bus write to the output register in the same cycle takes priority over the toggle.
- R9: After reset, the output, direction, mask, polarity, edge-select and pulse-enable registers and all map fields are 0.
- R10: Registers read back what was written. Map words read back with only bits 4:0 of each byte populated. Offsets with no register, such as 0x1C, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 16 | Input value from each pad |
| pad_out | output | 16 | Output value to each pad |
| pad_oe | output | 16 | Output-enable to each pad |
| pulse_in | input | 16 | Internal per-line toggle strobes |
| irq_out | output | 32 | Interrupt vector, registered |

## Verification
The interrupt path is driven with a held level of both polarities, which separates level sensing from edge sensing because the output must persist. It is also driven with single rising and falling transitions, where a pulse exactly one clock wide separates edge mode from level mode and the wrong-direction transition must stay silent. Mapping is tested with two lines on one vector bit, which shows OR merging, and with an out-of-range field, which shows that the value is dropped rather than wrapped. A remap to the top vector bit checks the field-to-bit arithmetic at its upper boundary. Pulse strobes are applied to enabled and disabled lines, and also together with a bus write, to expose the toggle's gating and its priority.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // word indices (byte offset / 4) of the register map
   localparam int unsigned WORD_DATA = 0;
   localparam int unsigned WORD_OUT  = 1;
   localparam int unsigned WORD_DIR  = 2;
   localparam int unsigned WORD_MASK = 3;
   localparam int unsigned WORD_POL  = 4;
   localparam int unsigned WORD_EDGE = 5;
   localparam int unsigned WORD_PEN  = 6;
   localparam int unsigned WORD_MAP  = 8;

   // width of one map field slot inside a map word
   localparam int unsigned FIELD_BITS = 8;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_OUT,
      SEL_DIR,
      SEL_MASK,
      SEL_POL,
      SEL_EDGE,
      SEL_PEN,
      SEL_MAP
   } reg_sel_e;

   function automatic reg_sel_e decode_word(input int unsigned widx,
                                            input int unsigned nmap);
      reg_sel_e s;
      if (widx == WORD_DATA)      s = SEL_DATA;
      else if (widx == WORD_OUT)  s = SEL_OUT;
      else if (widx == WORD_DIR)  s = SEL_DIR;
      else if (widx == WORD_MASK) s = SEL_MASK;
      else if (widx == WORD_POL)  s = SEL_POL;
      else if (widx == WORD_EDGE) s = SEL_EDGE;
      else if (widx == WORD_PEN)  s = SEL_PEN;
      else if (widx >= WORD_MAP && widx < WORD_MAP + nmap) s = SEL_MAP;
      else                        s = SEL_NONE;
      return s;
   endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_port_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_events.sv
module gpio_port_events #(
   parameter int unsigned NLINES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] lvl,
   input  logic [NLINES-1:0] mask,
   input  logic [NLINES-1:0] pol,
   input  logic [NLINES-1:0] edge_sel,
   output logic [NLINES-1:0] evt
);
   logic [NLINES-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < int'(NLINES); i++) begin : g_line
      logic rise, fall, lvl_hit, edg_hit;
      assign rise    = lvl[i] & ~prev[i];
      assign fall    = ~lvl[i] & prev[i];
      assign lvl_hit = pol[i] ? lvl[i] : ~lvl[i];
      assign edg_hit = pol[i] ? rise : fall;
      assign evt[i]  = mask[i] & (edge_sel[i] ? edg_hit : lvl_hit);
   end
endmodule

// File: rtl/gpio_port_irq_route.sv
module gpio_port_irq_route #(
   parameter int unsigned NLINES   = 16,
   parameter int unsigned MAP_W    = 5,
   parameter int unsigned IRQ_W    = 32,
   parameter int unsigned IRQ_BASE = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NLINES-1:0]       evt,
   input  logic [NLINES*MAP_W-1:0] map,
   output logic [IRQ_W-1:0]        irq
);
   localparam int unsigned NCODES = 1 << MAP_W;

   logic [IRQ_W-1:0] irq_next;

   for (genvar b = 0; b < int'(IRQ_W); b++) begin : g_bit
      if (b < int'(IRQ_BASE) || (b - int'(IRQ_BASE)) >= int'(NCODES)) begin : g_none
         assign irq_next[b] = 1'b0;
      end else begin : g_src
         logic [NLINES-1:0] hit;
         for (genvar i = 0; i < int'(NLINES); i++) begin : g_cmp
            assign hit[i] = evt[i] &&
                            (map[i*MAP_W +: MAP_W] == MAP_W'(b - int'(IRQ_BASE)));
         end
         assign irq_next[b] = |hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= '0;
      else        irq <= irq_next;
   end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned NLINES = 16,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MAP_W  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    wr,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W-1:0]       rdata,
   input  logic [NLINES-1:0]       sync_in,
   input  logic [NLINES-1:0]       pulse_in,
   output logic [NLINES-1:0]       out_q,
   output logic [NLINES-1:0]       dir_q,
   output logic [NLINES-1:0]       mask_q,
   output logic [NLINES-1:0]       pol_q,
   output logic [NLINES-1:0]       edge_q,
   output logic [NLINES-1:0]       pen_q,
   output logic [NLINES*MAP_W-1:0] map_q
);
   localparam int unsigned FIELDS = DATA_W / FIELD_BITS;
   localparam int unsigned NMAP   = (NLINES + FIELDS - 1) / FIELDS;
   localparam int unsigned WIDX_W = ADDR_W - 2;
   localparam int unsigned MIDX_W = (NMAP > 1) ? $clog2(NMAP) : 1;

   logic [WIDX_W-1:0] widx, moff;
   reg_sel_e          sel;
   logic [DATA_W-1:0] map_rd [NMAP];

   assign widx = addr[ADDR_W-1:2];
   assign moff = widx - WIDX_W'(WORD_MAP);
   assign sel  = decode_word(int'(widx), NMAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         mask_q <= '0;
         pol_q  <= '0;
         edge_q <= '0;
         pen_q  <= '0;
         map_q  <= '0;
      end else begin
         // bus write to the output register beats a toggle strobe
         if (wr && sel == SEL_OUT) out_q <= wdata[NLINES-1:0];
         else                      out_q <= out_q ^ (pulse_in & pen_q);
         if (wr && sel == SEL_DIR)  dir_q  <= wdata[NLINES-1:0];
         if (wr && sel == SEL_MASK) mask_q <= wdata[NLINES-1:0];
         if (wr && sel == SEL_POL)  pol_q  <= wdata[NLINES-1:0];
         if (wr && sel == SEL_EDGE) edge_q <= wdata[NLINES-1:0];
         if (wr && sel == SEL_PEN)  pen_q  <= wdata[NLINES-1:0];
         for (int i = 0; i < int'(NLINES); i++) begin
            if (wr && sel == SEL_MAP && int'(moff) == i / int'(FIELDS)) begin
               map_q[i*MAP_W +: MAP_W] <=
                  wdata[(i % int'(FIELDS))*int'(FIELD_BITS) +: MAP_W];
            end
         end
      end
   end

   always_comb begin
      for (int k = 0; k < int'(NMAP); k++) begin
         map_rd[k] = '0;
         for (int f = 0; f < int'(FIELDS); f++) begin
            if (k*int'(FIELDS) + f < int'(NLINES)) begin
               map_rd[k][f*int'(FIELD_BITS) +: MAP_W] =
                  map_q[(k*int'(FIELDS) + f)*int'(MAP_W) +: MAP_W];
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_DATA: rdata[NLINES-1:0] = sync_in;
         SEL_OUT:  rdata[NLINES-1:0] = out_q;
         SEL_DIR:  rdata[NLINES-1:0] = dir_q;
         SEL_MASK: rdata[NLINES-1:0] = mask_q;
         SEL_POL:  rdata[NLINES-1:0] = pol_q;
         SEL_EDGE: rdata[NLINES-1:0] = edge_q;
         SEL_PEN:  rdata[NLINES-1:0] = pen_q;
         SEL_MAP:  rdata = map_rd[moff[MIDX_W-1:0]];
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NLINES      = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned IRQ_W       = 32,
   parameter int unsigned IRQ_BASE    = 16,
   parameter int unsigned MAP_W       = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NLINES-1:0] pad_in,
   output logic [NLINES-1:0] pad_out,
   output logic [NLINES-1:0] pad_oe,
   input  logic [NLINES-1:0] pulse_in,
   output logic [IRQ_W-1:0]  irq_out
);
   localparam int unsigned FIELDS = DATA_W / FIELD_BITS;
   localparam int unsigned NMAP   = (NLINES + FIELDS - 1) / FIELDS;

   if (NLINES < 1 || NLINES > DATA_W) begin : g_bad_lines
      $error("gpio_irq_port: NLINES must be 1..DATA_W");
   end
   if (MAP_W < 1 || MAP_W > FIELD_BITS) begin : g_bad_map
      $error("gpio_irq_port: MAP_W must be 1..FIELD_BITS");
   end
   if (DATA_W % FIELD_BITS != 0) begin : g_bad_data
      $error("gpio_irq_port: DATA_W must be a multiple of FIELD_BITS");
   end
   if (IRQ_BASE >= IRQ_W) begin : g_bad_base
      $error("gpio_irq_port: IRQ_BASE must be below IRQ_W");
   end
   if (ADDR_W < 3 || WORD_MAP + NMAP > (1 << (ADDR_W - 2))) begin : g_bad_addr
      $error("gpio_irq_port: ADDR_W too small for the register map");
   end

   logic [NLINES-1:0]       line_lvl;
   logic [NLINES-1:0]       line_dir, line_mask, line_pol, line_edge, line_pen;
   logic [NLINES-1:0]       line_evt;
   logic [NLINES*MAP_W-1:0] line_map;

   gpio_port_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d (pad_in),
      .q (line_lvl)
   );

   gpio_port_regs #(
      .NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAP_W(MAP_W)
   ) u_regs (
      .clk (clk),
      .rst_n (rst_n),
      .addr (reg_addr),
      .wr (reg_wr),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .sync_in (line_lvl),
      .pulse_in (pulse_in),
      .out_q (pad_out),
      .dir_q (line_dir),
      .mask_q (line_mask),
      .pol_q (line_pol),
      .edge_q (line_edge),
      .pen_q (line_pen),
      .map_q (line_map)
   );

   assign pad_oe = line_dir;

   gpio_port_events #(.NLINES(NLINES)) u_events (
      .clk (clk),
      .rst_n (rst_n),
      .lvl (line_lvl),
      .mask (line_mask),
      .pol (line_pol),
      .edge_sel (line_edge),
      .evt (line_evt)
   );

   gpio_port_irq_route #(
      .NLINES(NLINES), .MAP_W(MAP_W), .IRQ_W(IRQ_W), .IRQ_BASE(IRQ_BASE)
   ) u_route (
      .clk (clk),
      .rst_n (rst_n),
      .evt (line_evt),
      .map (line_map),
      .irq (irq_out)
   );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
   parameter int unsigned NLINES   = 16,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IRQ_W    = 32,
   parameter int unsigned IRQ_BASE = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NLINES-1:0] pad_in,
   input logic [NLINES-1:0] pad_out,
   input logic [NLINES-1:0] pad_oe,
   input logic [NLINES-1:0] pulse_in,
   input logic [IRQ_W-1:0]  irq_out,
   input logic [NLINES-1:0] line_mask,
   input logic [NLINES-1:0] line_pen
);
   logic [ADDR_W-3:0] widx;
   logic [1:0]        cyc;

   assign widx = reg_addr[ADDR_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R1: data word shows pad input delayed by two edges
   a_r1_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (widx == '0 && cyc == 2'd3) |-> (reg_rdata[NLINES-1:0] == $past(pad_in, 2)));

   // R2: direction write reaches the enables
   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && widx == (ADDR_W-2)'(2)) |=> (pad_oe == $past(reg_wdata[NLINES-1:0])));

   // R3: output write reaches the pads
   a_r3_out_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && widx == (ADDR_W-2)'(1)) |=> (pad_out == $past(reg_wdata[NLINES-1:0])));

   // R4: all lines masked leaves the vector silent next cycle
   a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (line_mask == '0) |=> (irq_out == '0));

   // R8: without an output write, pads change only by enabled strobes
   a_r8_pulse_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && widx == (ADDR_W-2)'(1)) |=>
         (pad_out == ($past(pad_out) ^ $past(pulse_in & line_pen))));

   // R7: vector bits below the base are never used
   if (IRQ_BASE > 0) begin : g_low
      a_r7_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[IRQ_BASE-1:0] == '0);
   end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
   .NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .IRQ_W(IRQ_W), .IRQ_BASE(IRQ_BASE)
) u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .reg_addr (reg_addr),
   .reg_wr (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .pad_in (pad_in),
   .pad_out (pad_out),
   .pad_oe (pad_oe),
   .pulse_in (pulse_in),
   .irq_out (irq_out),
   .line_mask (line_mask),
   .line_pen (line_pen)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe;
   logic [15:0] pulse_in = '0;
   logic [31:0] irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_port uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pulse_in(pulse_in), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R9 pad_oe", {16'h0, pad_oe}, 32'h0);
      chk("R9 pad_out", {16'h0, pad_out}, 32'h0);
      chk("R9 irq_out", irq_out, 32'h0);
      for (int a = 4; a <= 8'h2C; a += 4) begin
         rd(8'(a), v);
         chk("R9 register zero", v, 32'h0);
      end
   endtask

   task automatic t_readback();
      logic [31:0] v;
      wr(8'h04, 32'h0000_A5A5);
      chk("R3 pad_out", {16'h0, pad_out}, 32'h0000_A5A5);
      rd(8'h04, v); chk("R10 out readback", v, 32'h0000_A5A5);
      wr(8'h08, 32'h0000_0F0F);
      chk("R2 pad_oe", {16'h0, pad_oe}, 32'h0000_0F0F);
      rd(8'h08, v); chk("R10 dir readback", v, 32'h0000_0F0F);
      wr(8'h10, 32'h0000_1234);
      rd(8'h10, v); chk("R10 pol readback", v, 32'h0000_1234);
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h20, v); chk("R10 map fields", v, 32'h1F1F_1F1F);
      rd(8'h24, v); chk("R10 other map word", v, 32'h0);
      rd(8'h1C, v); chk("R10 unused offset", v, 32'h0);
      wr(8'h00, 32'h0000_FFFF);
      rd(8'h00, v); chk("R1 data write ignored", v, 32'h0);
      wr(8'h20, 32'h0); wr(8'h10, 32'h0); wr(8'h08, 32'h0); wr(8'h04, 32'h0);
   endtask

   task automatic t_sync();
      logic [31:0] v;
      pad_in = 16'h00FF;
      wait_n(1);
      rd(8'h00, v); chk("R1 not yet visible", v, 32'h0);
      wait_n(1);
      rd(8'h00, v); chk("R1 visible after two", v, 32'h0000_00FF);
      pad_in = 16'h0;
      wait_n(3);
   endtask

   task automatic t_level();
      wr(8'h20, 32'h0200_0000);   // line 3 -> bit 18
      wr(8'h10, 32'h0000_0008);
      wr(8'h14, 32'h0);
      pad_in = 16'h0008;
      wait_n(3);
      chk("R4 masked line silent", irq_out, 32'h0);
      wr(8'h0C, 32'h0000_0008);
      wait_n(1);
      chk("R5 active high level", irq_out, 32'h0004_0000);
      wait_n(3);
      chk("R5 level held", irq_out, 32'h0004_0000);
      pad_in = 16'h0;
      wait_n(2);
      chk("R5 registered latency", irq_out, 32'h0004_0000);
      wait_n(1);
      chk("R5 level released", irq_out, 32'h0);
      wr(8'h10, 32'h0);
      wait_n(1);
      chk("R5 active low level", irq_out, 32'h0004_0000);
      wr(8'h0C, 32'h0);
      wait_n(1);
      chk("R4 mask cleared", irq_out, 32'h0);
      wr(8'h20, 32'h0);
   endtask

   task automatic t_edge();
      wr(8'h10, 32'h0000_0020);
      wr(8'h14, 32'h0000_0020);
      wr(8'h0C, 32'h0000_0020);   // line 5, map 0 -> bit 16
      wait_n(2);
      chk("R6 idle", irq_out, 32'h0);
      pad_in = 16'h0020;
      wait_n(3);
      chk("R6 rising pulse", irq_out, 32'h0001_0000);
      wait_n(1);
      chk("R6 pulse one cycle", irq_out, 32'h0);
      pad_in = 16'h0;
      wait_n(3);
      chk("R6 falling ignored in rising mode", irq_out, 32'h0);
      wr(8'h10, 32'h0);
      pad_in = 16'h0020;
      wait_n(3);
      chk("R6 rising ignored in falling mode", irq_out, 32'h0);
      pad_in = 16'h0;
      wait_n(3);
      chk("R6 falling pulse", irq_out, 32'h0001_0000);
      wait_n(1);
      chk("R6 falling one cycle", irq_out, 32'h0);
      wr(8'h0C, 32'h0); wr(8'h14, 32'h0);
   endtask

   task automatic t_map();
      wr(8'h10, 32'h0000_0007);
      wr(8'h20, 32'h0014_0707);   // lines 0,1 -> 7 ; line 2 -> 20 (dropped)
      wr(8'h0C, 32'h0000_0007);
      pad_in = 16'h0001;
      wait_n(3);
      chk("R7 line0 to bit 23", irq_out, 32'h0080_0000);
      pad_in = 16'h0004;
      wait_n(3);
      chk("R7 out of range dropped", irq_out, 32'h0);
      pad_in = 16'h0003;
      wait_n(3);
      chk("R7 shared bit OR", irq_out, 32'h0080_0000);
      wr(8'h20, 32'h0014_0F07);   // line 1 -> 15 -> bit 31
      wait_n(1);
      chk("R7 top bit and OR", irq_out, 32'h8080_0000);
      wr(8'h0C, 32'h0); wr(8'h20, 32'h0); wr(8'h10, 32'h0);
      pad_in = 16'h0;
      wait_n(3);
   endtask

   task automatic t_pulse();
      logic [31:0] v;
      wr(8'h18, 32'h0000_0003);
      pulse_in = 16'h000F;
      @(negedge clk);
      pulse_in = 16'h0;
      chk("R8 enabled lines toggle", {16'h0, pad_out}, 32'h0000_0003);
      rd(8'h04, v); chk("R8 output register toggled", v, 32'h0000_0003);
      pulse_in = 16'h0001;
      @(negedge clk);
      pulse_in = 16'h0;
      chk("R8 toggle back", {16'h0, pad_out}, 32'h0000_0002);
      pulse_in = 16'h0002;
      reg_addr = 8'h04; reg_wdata = 32'h0000_8000; reg_wr = 1'b1;
      @(negedge clk);
      pulse_in = 16'h0; reg_wr = 1'b0;
      chk("R8 write beats toggle", {16'h0, pad_out}, 32'h0000_8000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_sync();
      t_level();
      t_edge();
      t_map();
      t_pulse();
      finish_up();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end
endmodule